// File: doc/BRIEF.md
# Selectable-Width Stack Address Generator

This block forms the stack addresses for an 8051-style processor core. It keeps an 8-bit stack pointer and an 8-bit extension register. A mode bit in a small control register decides how many address bits a stack access uses. With the mode bit clear, an access addresses internal direct RAM with the 8-bit pointer alone. With the mode bit set, the two low bits of the extension register sit above the pointer to form a 10-bit address. That address selects a location in the lowest 1 KB of external-data memory.

The core requests stack operations with a push strobe or a pop strobe. A push advances the pointer and then stores, so the access uses the new value. A pop uses the current value and then steps the pointer back. For each accepted operation, one registered access record appears on the next cycle: a valid flag, a write flag, the address and a memory select. The core writes the pointer and the extension register directly. The mode bit can change only in a cycle where the external timed-access enable is high. The block refuses to set the mode bit while the memory-configuration input shows the one code that cannot host an external stack.

Top module: `stack_addr_gen`

## Requirements
- R1: After reset the pointer reads 07h, the extension register reads 00h, the control register reads F8h (mode bit clear) and `acc_vld` is 0.
- R2: With the mode bit (control bit 2) clear, a push makes the pointer equal to pointer+1 modulo 256. On the next cycle `acc_vld`=1, `acc_wr`=1, `acc_sel`=0, and `acc_addr` has bits 9:8 at zero and the new pointer in bits 7:0. The extension register is not changed.
- R3: With the mode bit clear, a pop sets `acc_vld`=1, `acc_wr`=0 and `acc_sel`=0 with the pointer value from before the pop in `acc_addr`. The pointer then becomes pointer-1 modulo 256, so 00h steps to FFh.
- R4: With the mode bit set, every access addresses {extension bits 1:0, pointer} and drives `acc_sel`=1. A push uses the incremented 10-bit value; a pop uses the current value.
- R5: With the mode bit set, a push carries out of the pointer into extension bits 1:0, and a pop borrows from them. The 10-bit value wraps from 3FFh to 000h and back. Extension bits 7:2 are kept.
- R6: A control write changes the mode bit only when `ta_open` is 1 in the same cycle. Writing 0 to bit 2 clears the bit; writing 1 sets it.
- R7: A write that would set the mode bit has no effect while `mem_cfg` equals 2'b11. Clearing the bit is allowed under any `mem_cfg`.
- R8: Control bits 7:3 always read 1 and bits 1:0 always read 0, whatever value is written.
- R9: A cycle with both push and pop is not a stack operation. A cycle that writes the pointer or the extension register does not perform the stack operation either. In such a cycle no access record is produced (`acc_vld`=0) and the pointer changes only through the direct write.
- R10: A direct write loads the full 8-bit value into the pointer or the extension register, and the loaded value reads back on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push | input | 1 | Push request |
| pop | input | 1 | Pop request |
| sp_we | input | 1 | Write strobe for the stack pointer |
| sp_wd | input | 8 | Stack pointer write data |
| ext_we | input | 1 | Write strobe for the extension register |
| ext_wd | input | 8 | Extension register write data |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wd | input | 8 | Control register write data |
| ta_open | input | 1 | Timed-access window is open |
| mem_cfg | input | 2 | Memory configuration code; 2'b11 blocks setting the mode bit |
| sp_q | output | 8 | Stack pointer read value |
| ext_q | output | 8 | Extension register read value |
| ctl_q | output | 8 | Control register read value |
| acc_vld | output | 1 | Access record valid |
| acc_wr | output | 1 | Access is a store (push) when 1, a load (pop) when 0 |
| acc_addr | output | 10 | Stack access address |
| acc_sel | output | 1 | 0 = internal direct RAM, 1 = external-data memory |

## Verification
The hardest case to reach from the ports is the 10-bit wrap in both directions while the upper extension bits hold a non-zero pattern. Reaching it needs the timed-access window, a permitted memory code and direct loads of both registers before a single push or pop. The stimulus loads the extension register with patterns such as 57h and A6h and puts the pointer at FEh or FFh. It then pushes across the 2FFh→300h carry and the 3FFh→000h wrap, and pops back across the borrow. A behavioural reference model is compared against every output on every cycle of this sequence.

// File: rtl/sag_pkg.sv
package sag_pkg;

   typedef enum logic {
      DIR_POP  = 1'b0,
      DIR_PUSH = 1'b1
   } stk_dir_e;

   // a stack operation goes ahead only for a single strobe in a cycle
   // without a direct register write
   function automatic logic op_accepted(input logic push_i,
                                        input logic pop_i,
                                        input logic sp_wr_i,
                                        input logic ext_wr_i);
      return (push_i ^ pop_i) & ~sp_wr_i & ~ext_wr_i;
   endfunction

endpackage

// File: rtl/sag_mode_reg.sv
module sag_mode_reg #(
   parameter int                 REG_W     = 8,
   parameter int                 RSVD_W    = 5,
   parameter int                 CFG_W     = 2,
   parameter logic [CFG_W-1:0]   BLOCK_CFG = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             unlock,
   input  logic [CFG_W-1:0] mem_cfg,
   output logic             mode,
   output logic [REG_W-1:0] ctl_q
);
   localparam int MODE_POS = REG_W - RSVD_W - 1;

   initial begin : p_param_check
      if (MODE_POS < 0) $fatal(1, "sag_mode_reg: no room for the mode bit");
      if (CFG_W < 1)    $fatal(1, "sag_mode_reg: CFG_W must be positive");
   end

   logic mode_r;
   logic set_req;
   logic clr_req;
   logic unused_wd;

   assign unused_wd = ^wr_data;
   assign set_req   = wr_en & unlock &  wr_data[MODE_POS] & (mem_cfg != BLOCK_CFG);
   assign clr_req   = wr_en & unlock & ~wr_data[MODE_POS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_r <= 1'b0;
      else if (set_req) mode_r <= 1'b1;
      else if (clr_req) mode_r <= 1'b0;
   end

   assign mode = mode_r;

   generate
      if (MODE_POS > 0) begin : g_low_pad
         assign ctl_q = {{RSVD_W{1'b1}}, mode_r, {MODE_POS{1'b0}}};
      end else begin : g_no_pad
         assign ctl_q = {{RSVD_W{1'b1}}, mode_r};
      end
   endgenerate

   // R6: without the timed-access window the mode bit holds
   a_r6_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(unlock) |-> $stable(mode_r));

   // R7: the mode bit never rises out of a blocked memory configuration
   a_r7_no_set_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_r) |-> ($past(mem_cfg) != BLOCK_CFG));

endmodule

// File: rtl/sag_pointer.sv
module sag_pointer #(
   parameter int               PTR_W   = 8,
   parameter int               EXT_USE = 2,
   parameter int               REG_W   = 8,
   parameter logic [PTR_W-1:0] SP_RST  = 8'h07,
   parameter logic [REG_W-1:0] EXT_RST = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     op_go,
   input  logic                     op_push,
   input  logic                     wide,
   input  logic                     sp_we,
   input  logic [PTR_W-1:0]         sp_wd,
   input  logic                     ext_we,
   input  logic [REG_W-1:0]         ext_wd,
   output logic [PTR_W-1:0]         sp_q,
   output logic [REG_W-1:0]         ext_q,
   output logic [PTR_W+EXT_USE-1:0] cur_addr,
   output logic [PTR_W+EXT_USE-1:0] inc_addr
);
   localparam int FULL_W = PTR_W + EXT_USE;
   localparam logic [PTR_W-1:0]  ONE_P = 1;
   localparam logic [FULL_W-1:0] ONE_F = 1;

   initial begin : p_param_check
      if (EXT_USE < 1)     $fatal(1, "sag_pointer: EXT_USE must be at least 1");
      if (EXT_USE > REG_W) $fatal(1, "sag_pointer: EXT_USE exceeds register width");
      if (PTR_W != REG_W)  $fatal(1, "sag_pointer: pointer and register widths differ");
   end

   logic [PTR_W-1:0]   sp_r;
   logic [EXT_USE-1:0] ext_lo_r;
   logic [FULL_W-1:0]  wide_cur;
   logic [FULL_W-1:0]  narrow_cur;
   logic [FULL_W-1:0]  wide_inc;
   logic [FULL_W-1:0]  wide_dec;
   logic [PTR_W-1:0]   narrow_inc;
   logic [PTR_W-1:0]   narrow_dec;
   logic [FULL_W-1:0]  dec_addr;
   logic [FULL_W-1:0]  step_addr;

   assign wide_cur   = {ext_lo_r, sp_r};
   assign narrow_cur = {{EXT_USE{1'b0}}, sp_r};
   assign wide_inc   = wide_cur + ONE_F;
   assign wide_dec   = wide_cur - ONE_F;
   assign narrow_inc = sp_r + ONE_P;
   assign narrow_dec = sp_r - ONE_P;

   always_comb begin
      if (wide) begin
         cur_addr = wide_cur;
         inc_addr = wide_inc;
         dec_addr = wide_dec;
      end else begin
         cur_addr = narrow_cur;
         inc_addr = {{EXT_USE{1'b0}}, narrow_inc};
         dec_addr = {{EXT_USE{1'b0}}, narrow_dec};
      end
      step_addr = op_push ? inc_addr : dec_addr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sp_r <= SP_RST;
      else if (sp_we) sp_r <= sp_wd;
      else if (op_go) sp_r <= step_addr[PTR_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ext_lo_r <= EXT_RST[EXT_USE-1:0];
      else if (ext_we)         ext_lo_r <= ext_wd[EXT_USE-1:0];
      else if (op_go && wide)  ext_lo_r <= step_addr[FULL_W-1:PTR_W];
   end

   generate
      if (REG_W > EXT_USE) begin : g_ext_hi
         logic [REG_W-EXT_USE-1:0] ext_hi_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      ext_hi_r <= EXT_RST[REG_W-1:EXT_USE];
            else if (ext_we) ext_hi_r <= ext_wd[REG_W-1:EXT_USE];
         end
         assign ext_q = {ext_hi_r, ext_lo_r};
      end else begin : g_ext_full
         assign ext_q = ext_lo_r;
      end
   endgenerate

   assign sp_q = sp_r;

   // R10: a direct pointer write is what reads back next
   a_r10_sp_load: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sp_we) |-> (sp_r == $past(sp_wd)));

   // R2: narrow stack traffic leaves the extension register alone
   a_r2_narrow_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_go) && !$past(wide)) |-> $stable(ext_lo_r));

endmodule

// File: rtl/sag_access_reg.sv
module sag_access_reg #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_go,
   input  logic              op_push,
   input  logic              wide,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [ADDR_W-1:0] inc_addr,
   output logic              acc_vld,
   output logic              acc_wr,
   output logic [ADDR_W-1:0] acc_addr,
   output logic              acc_sel
);
   import sag_pkg::*;

   stk_dir_e dir;
   assign dir = op_push ? DIR_PUSH : DIR_POP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_vld <= 1'b0;
      else        acc_vld <= op_go;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_wr   <= 1'b0;
         acc_addr <= '0;
         acc_sel  <= 1'b0;
      end else if (op_go) begin
         acc_wr   <= (dir == DIR_PUSH);
         acc_addr <= (dir == DIR_PUSH) ? inc_addr : cur_addr;
         acc_sel  <= wide;
      end
   end

   // R4: the select of a record matches the mode of the cycle that made it
   a_r4_sel_tracks_mode: assert property (@(posedge clk) disable iff (!rst_n)
      acc_vld |-> (acc_sel == $past(wide)));

endmodule

// File: rtl/stack_addr_gen.sv
module stack_addr_gen #(
   parameter int                 PTR_W     = 8,
   parameter int                 EXT_USE   = 2,
   parameter int                 RSVD_W    = 5,
   parameter int                 CFG_W     = 2,
   parameter logic [CFG_W-1:0]   BLOCK_CFG = 2'b11,
   parameter logic [PTR_W-1:0]   SP_RST    = 8'h07,
   localparam int                ADDR_W    = PTR_W + EXT_USE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic              sp_we,
   input  logic [PTR_W-1:0]  sp_wd,
   input  logic              ext_we,
   input  logic [PTR_W-1:0]  ext_wd,
   input  logic              ctl_we,
   input  logic [PTR_W-1:0]  ctl_wd,
   input  logic              ta_open,
   input  logic [CFG_W-1:0]  mem_cfg,
   output logic [PTR_W-1:0]  sp_q,
   output logic [PTR_W-1:0]  ext_q,
   output logic [PTR_W-1:0]  ctl_q,
   output logic              acc_vld,
   output logic              acc_wr,
   output logic [ADDR_W-1:0] acc_addr,
   output logic              acc_sel
);
   import sag_pkg::*;

   logic              op_go;
   logic              mode;
   logic [ADDR_W-1:0] cur_addr;
   logic [ADDR_W-1:0] inc_addr;

   assign op_go = op_accepted(push, pop, sp_we, ext_we);

   sag_mode_reg #(
      .REG_W     (PTR_W),
      .RSVD_W    (RSVD_W),
      .CFG_W     (CFG_W),
      .BLOCK_CFG (BLOCK_CFG)
   ) mode_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ctl_we),
      .wr_data (ctl_wd),
      .unlock  (ta_open),
      .mem_cfg (mem_cfg),
      .mode    (mode),
      .ctl_q   (ctl_q)
   );

   sag_pointer #(
      .PTR_W   (PTR_W),
      .EXT_USE (EXT_USE),
      .REG_W   (PTR_W),
      .SP_RST  (SP_RST),
      .EXT_RST ('0)
   ) ptr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_go    (op_go),
      .op_push  (push),
      .wide     (mode),
      .sp_we    (sp_we),
      .sp_wd    (sp_wd),
      .ext_we   (ext_we),
      .ext_wd   (ext_wd),
      .sp_q     (sp_q),
      .ext_q    (ext_q),
      .cur_addr (cur_addr),
      .inc_addr (inc_addr)
   );

   sag_access_reg #(
      .ADDR_W (ADDR_W)
   ) acc_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_go    (op_go),
      .op_push  (push),
      .wide     (mode),
      .cur_addr (cur_addr),
      .inc_addr (inc_addr),
      .acc_vld  (acc_vld),
      .acc_wr   (acc_wr),
      .acc_addr (acc_addr),
      .acc_sel  (acc_sel)
   );

   // R3: a pop reports the pointer value seen at the port before it moved
   a_r3_pop_uses_old: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_go) && $past(pop)) |->
         (acc_addr == $past(mode ? {ext_q[EXT_USE-1:0], sp_q}
                                 : {{EXT_USE{1'b0}}, sp_q})));

   // R5: a wide push from the top of the region wraps to zero
   a_r5_wide_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_go) && $past(push) && $past(mode) && ($past(sp_q) == '1) &&
       ($past(ext_q[EXT_USE-1:0]) == '1)) |->
         ((acc_addr == '0) && (sp_q == '0) && (ext_q[EXT_USE-1:0] == '0)));

   // R9: conflicting requests produce no record
   a_r9_no_record: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(push) && $past(pop)) |-> !acc_vld);

endmodule

// File: tb/stack_addr_gen_tb_top.sv
`timescale 1ns/1ps
module stack_addr_gen_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       push = 0, pop = 0, sp_we = 0, ext_we = 0, ctl_we = 0, ta_open = 0;
   logic [7:0] sp_wd = 0, ext_wd = 0, ctl_wd = 0;
   logic [1:0] mem_cfg = 0;
   logic [7:0] sp_q, ext_q, ctl_q;
   logic       acc_vld, acc_wr, acc_sel;
   logic [9:0] acc_addr;

   int n_chk = 0;
   int n_fail = 0;
   int cyc_cnt = 0;
   string req = "R1";

   // reference model state
   int m_sp = 8'h07, m_ext = 0, m_mode = 0;
   int m_vld = 0, m_wr = 0, m_addr = 0, m_sel = 0;

   always #10 clk = ~clk;

   stack_addr_gen dut_i (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
      .sp_we(sp_we), .sp_wd(sp_wd), .ext_we(ext_we), .ext_wd(ext_wd),
      .ctl_we(ctl_we), .ctl_wd(ctl_wd), .ta_open(ta_open), .mem_cfg(mem_cfg),
      .sp_q(sp_q), .ext_q(ext_q), .ctl_q(ctl_q),
      .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_sel(acc_sel)
   );

   task automatic report_end();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc_cnt++;
      if (cyc_cnt > 20000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer than 20000)", cyc_cnt);
         report_end();
      end
   end

   task automatic chk(string r, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
      end
   endtask

   task automatic compare_all();
      chk(req, "sp_q", int'(sp_q), m_sp);
      chk(req, "ext_q", int'(ext_q), m_ext);
      chk(req, "ctl_q", int'(ctl_q), 'hF8 | (m_mode << 2));
      chk(req, "acc_vld", int'(acc_vld), m_vld);
      if (m_vld != 0) begin
         chk(req, "acc_wr", int'(acc_wr), m_wr);
         chk(req, "acc_addr", int'(acc_addr), m_addr);
         chk(req, "acc_sel", int'(acc_sel), m_sel);
      end
   endtask

   // one clock: drive at negedge, model at posedge, compare at next negedge
   task automatic cyc(bit pu, bit po, bit spw, int spd, bit exw, int exd,
                      bit cw, int cd, bit ul, int cfg);
      int comb, nc;
      bit go;
      push = pu; pop = po; sp_we = spw; sp_wd = 8'(spd);
      ext_we = exw; ext_wd = 8'(exd); ctl_we = cw; ctl_wd = 8'(cd);
      ta_open = ul; mem_cfg = 2'(cfg);
      @(posedge clk);
      go = (pu != po) && !spw && !exw;
      comb = m_mode ? (((m_ext % 4) * 256) + m_sp) : m_sp;
      m_vld = go;
      if (go) begin
         m_wr = pu;
         m_sel = m_mode;
         if (pu) begin
            nc = m_mode ? (comb + 1) % 1024 : (m_sp + 1) % 256;
            m_addr = nc;
         end else begin
            m_addr = comb;
            nc = m_mode ? (comb + 1023) % 1024 : (m_sp + 255) % 256;
         end
         m_sp = nc % 256;
         if (m_mode != 0) m_ext = (m_ext / 4) * 4 + nc / 256;
      end
      if (spw) m_sp = spd;
      if (exw) m_ext = exd;
      if (cw && ul) begin
         if ((cd & 4) != 0) begin
            if (cfg != 3) m_mode = 1;
         end else m_mode = 0;
      end
      @(negedge clk);
      compare_all();
   endtask

   task automatic do_push(); cyc(1,0,0,0,0,0,0,0,0,0); endtask
   task automatic do_pop();  cyc(0,1,0,0,0,0,0,0,0,0); endtask
   task automatic wr_sp(int v);  cyc(0,0,1,v,0,0,0,0,0,0); endtask
   task automatic wr_ext(int v); cyc(0,0,0,0,1,v,0,0,0,0); endtask
   task automatic wr_ctl(int v, bit ul, int cfg); cyc(0,0,0,0,0,0,1,v,ul,cfg); endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset values before release
      chk("R1", "sp_q reset", int'(sp_q), 'h07);
      chk("R1", "ext_q reset", int'(ext_q), 'h00);
      chk("R1", "ctl_q reset", int'(ctl_q), 'hF8);
      chk("R1", "acc_vld reset", int'(acc_vld), 0);
      rst_n = 1'b1;
      cyc(0,0,0,0,0,0,0,0,0,0);

      // R2: narrow pushes, extension bits ignored, wrap FFh->00h
      req = "R10"; wr_ext('h03);
      req = "R2";  do_push(); do_push();
      chk("R2", "narrow push addr", int'(acc_addr), 'h009);
      chk("R2", "narrow push sel", int'(acc_sel), 0);
      req = "R10"; wr_sp('hFE);
      req = "R2";  do_push(); do_push();
      chk("R2", "narrow wrap addr", int'(acc_addr), 'h000);
      chk("R2", "ext untouched", int'(ext_q), 'h03);

      // R3: narrow pops with wrap 00h->FFh
      req = "R3";  do_pop();
      chk("R3", "pop old value", int'(acc_addr), 'h000);
      chk("R3", "pointer after wrap", int'(sp_q), 'hFF);
      do_pop(); do_pop();

      // R6: no window, mode stays clear
      req = "R6"; wr_ctl('h04, 0, 0);
      chk("R6", "mode without window", int'(ctl_q), 'hF8);
      // R7: blocked configuration
      req = "R7"; wr_ctl('h04, 1, 3);
      chk("R7", "set blocked", int'(ctl_q), 'hF8);
      // R6: permitted set
      req = "R6"; wr_ctl('h04, 1, 1);
      chk("R6", "mode set", int'(ctl_q), 'hFC);
      // R8: reserved and low bits not writable
      req = "R8"; wr_ctl('hFF, 1, 2);
      chk("R8", "fixed bits", int'(ctl_q), 'hFC);
      req = "R8"; wr_ctl('h07, 1, 0);
      chk("R8", "upper ones", int'(ctl_q), 'hFC);

      // R4/R5: wide mode, carry into extension, upper bits kept
      req = "R10"; wr_ext('hA6); wr_sp('hFE);
      req = "R4";  do_push();
      chk("R4", "wide push addr", int'(acc_addr), 'h2FF);
      chk("R4", "wide sel", int'(acc_sel), 1);
      req = "R5";  do_push();
      chk("R5", "carry addr", int'(acc_addr), 'h300);
      chk("R5", "carry ext", int'(ext_q), 'hA7);
      do_push();
      req = "R4";  do_pop();
      chk("R4", "wide pop addr", int'(acc_addr), 'h301);
      req = "R5";  do_pop(); do_pop();
      chk("R5", "borrow ext", int'(ext_q), 'hA6);
      req = "R10"; wr_ext('h57); wr_sp('hFF);
      req = "R5";  do_push();
      chk("R5", "wrap 3FFh to 000h", int'(acc_addr), 'h000);
      chk("R5", "ext after wrap", int'(ext_q), 'h54);
      do_pop();
      chk("R5", "pop wrap ext", int'(ext_q), 'h57);
      chk("R5", "pop wrap sp", int'(sp_q), 'hFF);

      // R9: conflicts
      req = "R9"; cyc(1,1,0,0,0,0,0,0,0,0);
      chk("R9", "push+pop no record", int'(acc_vld), 0);
      cyc(1,0,1,'h40,0,0,0,0,0,0);
      chk("R9", "push with sp write", int'(sp_q), 'h40);
      cyc(0,1,0,0,1,'h11,0,0,0,0);
      chk("R9", "pop with ext write", int'(acc_vld), 0);
      do_push();

      // R7: clearing allowed under the blocked configuration
      req = "R7"; wr_ctl('h00, 1, 3);
      chk("R7", "clear under blocked cfg", int'(ctl_q), 'hF8);
      req = "R2"; do_push(); do_pop();

      report_end();
   end

endmodule